// File: doc/BRIEF.md
# Windowed sync activity monitor

This block tells a video receiver which of its sync inputs are alive. It has two channels. Each channel has three monitored lines: vertical sync, horizontal sync and an embedded-sync indication taken from the sync slicer. Time on the crystal clock is cut into equal windows that follow each other with no gap. During a window the block counts both rising and falling edges on every line. At the window boundary it turns each count into an activity flag.

Each channel also has a sticky status bit. The bit goes high whenever any of that channel's three flags changes value. Two interrupt lines, each with its own per-channel mask, report the status bits. Firmware polls the flags, or waits for an interrupt, and then decides which sync source to use.

Top module: `sync_activity_monitor`

## Requirements
- R1: A window lasts 2^WIN_LOG2 crystal cycles and windows repeat without gaps. The first window starts at the first clock edge after reset is released. The flags take their new values at the clock edge that ends each window, which is the (k·2^WIN_LOG2)-th edge after reset release.
- R2: Between two window boundaries the activity flags do not change.
- R3: A flag becomes 1 when four or more edges (rising and falling both count) reached that line's synchronizer during the window, exactly four included.
- R4: A flag becomes 0 when fewer than four edges were seen during the window. Three edges give 0.
- R5: The edge count saturates, so a very busy line still reads 1. The count restarts at every boundary, so a line that goes quiet after a busy window reads 0.
- R6: A channel's status bit stays high until that channel's clear strobe is sampled high.
- R7: A channel's status bit is set one cycle after any of its three flags changes. If the clear strobe arrives in that same cycle, the set wins.
- R8: irq_a is the OR over channels of (status AND mask_a). irq_b is the same, using mask_b.
- R9: An embedded-sync flag can only become 1 when that channel's detect enable and slicer data-valid are both high in the last cycle of the window. Otherwise it is 0, whatever the edge count.
- R10: After reset all flags, status bits and interrupt lines are 0.
- R11: The two channels are independent. Clearing or toggling one channel does not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vs_in | input | NCH | Vertical sync line per channel (asynchronous) |
| hs_in | input | NCH | Horizontal sync line per channel (asynchronous) |
| es_in | input | NCH | Embedded-sync indication per channel (asynchronous) |
| es_det_en | input | NCH | Embedded-sync detection enable per channel |
| es_dvalid | input | NCH | Slicer data-valid per channel |
| clr_stat | input | NCH | Clear strobe for the status bit per channel |
| mask_a | input | NCH | Per-channel mask for irq_a |
| mask_b | input | NCH | Per-channel mask for irq_b |
| vs_act | output | NCH | Vertical sync activity flag |
| hs_act | output | NCH | Horizontal sync activity flag |
| es_act | output | NCH | Embedded-sync activity flag |
| stat | output | NCH | Sticky result-changed status |
| irq_a | output | 1 | Masked interrupt line A |
| irq_b | output | 1 | Masked interrupt line B |

## Verification
The bench targets the threshold with windows of exactly three and exactly four edges. A design with an off-by-one compare would flip the flag in one of these windows. It also runs a busy window followed by a silent one; a counter that is not cleared at the boundary would keep reporting activity. A clear strobe is placed in the same cycle as a status set, which a clear-first design would lose. Further windows drop the enable or the data-valid while the embedded line toggles, and swap masks between the two interrupt lines, so crossed gating or crossed masks appear as wrong flags or wrong interrupt levels.

// File: rtl/sam_pkg.sv
// Shared constants and types for the sync activity monitor.
// Assumes three monitored lines per channel, indexed by sig_kind_e.
package sam_pkg;
    localparam int NUM_CH     = 2;
    localparam int SIG_PER_CH = 3;

    typedef enum logic [1:0] {
        SIG_VS = 2'd0,
        SIG_HS = 2'd1,
        SIG_ES = 2'd2
    } sig_kind_e;
endpackage

// File: rtl/sam_window_timer.sv
// Free-running window timer. It gives a one-cycle pulse in the last cycle
// of every 2^WIN_LOG2-cycle window.
// Assumes: the first window starts at the first edge after reset release.
module sam_window_timer #(
    parameter int WIN_LOG2 = 22
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end
);
    logic [WIN_LOG2-1:0] tick_q;

    // Purpose: advance the window position and wrap it naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_q + 1'b1;
    end

    assign win_end = &tick_q;
endmodule

// File: rtl/sam_edge_tally.sv
// One monitored line: a two-flop synchronizer, detection of both edges,
// a saturating edge count, and the activity flag registered at window end.
// Assumes: qualify is already in the clk domain and is sampled only in the
// win_end cycle.
module sam_edge_tally #(
    parameter int MIN_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic win_end,
    input  logic qualify,
    output logic act
);
    localparam int CNT_W = $clog2(MIN_EDGES + 1);

    logic [1:0]       sync_q;
    logic             last_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             edge_seen;

    // Purpose: bring the line into the clk domain and keep its last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], sig_in};
            last_q <= sync_q[1];
        end
    end

    assign edge_seen = sync_q[1] ^ last_q;

    // Purpose: count edges, but stop at the threshold.
    always_comb begin
        if (cnt_q >= CNT_W'(MIN_EDGES)) cnt_inc = cnt_q;
        else                            cnt_inc = cnt_q + CNT_W'(edge_seen);
    end

    // Purpose: count edges, and at window end latch the flag and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act   <= 1'b0;
        end else if (win_end) begin
            cnt_q <= '0;
            act   <= qualify && (cnt_inc >= CNT_W'(MIN_EDGES));
        end else begin
            cnt_q <= cnt_inc;
        end
    end
endmodule

// File: rtl/sam_irq_ctrl.sv
// Per-channel sticky change status and two masked interrupt lines.
// Assumes: flags change only at window boundaries. A change is seen one
// cycle later, and a set has priority over a clear in the same cycle.
module sam_irq_ctrl #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] vs_act,
    input  logic [NCH-1:0] hs_act,
    input  logic [NCH-1:0] es_act,
    input  logic [NCH-1:0] clr_stat,
    input  logic [NCH-1:0] mask_a,
    input  logic [NCH-1:0] mask_b,
    output logic [NCH-1:0] stat,
    output logic           irq_a,
    output logic           irq_b
);
    logic [NCH-1:0] vs_p, hs_p, es_p;
    logic [NCH-1:0] chg;

    // Purpose: keep last cycle's flags so that a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_p <= '0;
            hs_p <= '0;
            es_p <= '0;
        end else begin
            vs_p <= vs_act;
            hs_p <= hs_act;
            es_p <= es_act;
        end
    end

    assign chg = (vs_act ^ vs_p) | (hs_act ^ hs_p) | (es_act ^ es_p);

    // Purpose: sticky status, where a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_stat) | chg;
    end

    assign irq_a = |(stat & mask_a);
    assign irq_b = |(stat & mask_b);
endmodule

// File: rtl/sync_activity_monitor.sv
// Top of the sync activity monitor. There is one window timer for all lines,
// one edge tally per monitored line, and one interrupt controller.
// Assumes: es_det_en and es_dvalid are already synchronous to clk.
module sync_activity_monitor #(
    parameter int WIN_LOG2  = 22,
    parameter int MIN_EDGES = 4,
    parameter int NCH       = sam_pkg::NUM_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] vs_in,
    input  logic [NCH-1:0] hs_in,
    input  logic [NCH-1:0] es_in,
    input  logic [NCH-1:0] es_det_en,
    input  logic [NCH-1:0] es_dvalid,
    input  logic [NCH-1:0] clr_stat,
    input  logic [NCH-1:0] mask_a,
    input  logic [NCH-1:0] mask_b,
    output logic [NCH-1:0] vs_act,
    output logic [NCH-1:0] hs_act,
    output logic [NCH-1:0] es_act,
    output logic [NCH-1:0] stat,
    output logic           irq_a,
    output logic           irq_b
);
    import sam_pkg::*;

    logic win_end;
    logic [NCH-1:0][SIG_PER_CH-1:0] act_w;

    sam_window_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_end (win_end)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SIG_PER_CH-1:0] pin_w;
        logic [SIG_PER_CH-1:0] qual_w;

        assign pin_w[SIG_VS]  = vs_in[c];
        assign pin_w[SIG_HS]  = hs_in[c];
        assign pin_w[SIG_ES]  = es_in[c];
        assign qual_w[SIG_VS] = 1'b1;
        assign qual_w[SIG_HS] = 1'b1;
        assign qual_w[SIG_ES] = es_det_en[c] & es_dvalid[c];

        for (genvar k = 0; k < SIG_PER_CH; k++) begin : g_sig
            sam_edge_tally #(.MIN_EDGES(MIN_EDGES)) u_tally (
                .clk     (clk),
                .rst_n   (rst_n),
                .sig_in  (pin_w[k]),
                .win_end (win_end),
                .qualify (qual_w[k]),
                .act     (act_w[c][k])
            );
        end

        assign vs_act[c] = act_w[c][SIG_VS];
        assign hs_act[c] = act_w[c][SIG_HS];
        assign es_act[c] = act_w[c][SIG_ES];
    end

    sam_irq_ctrl #(.NCH(NCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .vs_act   (vs_act),
        .hs_act   (hs_act),
        .es_act   (es_act),
        .clr_stat (clr_stat),
        .mask_a   (mask_a),
        .mask_b   (mask_b),
        .stat     (stat),
        .irq_a    (irq_a),
        .irq_b    (irq_b)
    );
endmodule

// File: rtl/sam_monitor_checks.sv
// Port-level properties of the sync activity monitor. The module is attached
// to the top by a bind. It keeps its own window position and a copy of the
// previous flags.
module sam_monitor_checks #(
    parameter int WIN_LOG2 = 22,
    parameter int NCH      = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] vs_act,
    input logic [NCH-1:0] hs_act,
    input logic [NCH-1:0] es_act,
    input logic [NCH-1:0] es_det_en,
    input logic [NCH-1:0] es_dvalid,
    input logic [NCH-1:0] clr_stat,
    input logic [NCH-1:0] mask_a,
    input logic [NCH-1:0] mask_b,
    input logic [NCH-1:0] stat,
    input logic           irq_a,
    input logic           irq_b
);
    logic [WIN_LOG2-1:0] pos_q;
    logic [NCH-1:0]      vs_p, hs_p, es_p;
    logic [NCH-1:0]      chg;

    // Purpose: independent window position and flag history for the checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            vs_p  <= '0;
            hs_p  <= '0;
            es_p  <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
            vs_p  <= vs_act;
            hs_p  <= hs_act;
            es_p  <= es_act;
        end
    end

    assign chg = (vs_act ^ vs_p) | (hs_act ^ hs_p) | (es_act ^ es_p);

    p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != '1) |=> $stable({vs_act, hs_act, es_act}));

    p_stat_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat) & ~$past(clr_stat)) & ~stat) == '0));

    p_set_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg) |=> ((stat & $past(chg)) == $past(chg)));

    p_irq_a_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |-> (|(stat & mask_a)));

    p_irq_b_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b |-> (|(stat & mask_b)));

    p_es_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((es_act & ~$past(es_act) & ~$past(es_det_en & es_dvalid)) == '0));
endmodule

bind sync_activity_monitor sam_monitor_checks #(
    .WIN_LOG2 (WIN_LOG2),
    .NCH      (NCH)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .vs_act    (vs_act),
    .hs_act    (hs_act),
    .es_act    (es_act),
    .es_det_en (es_det_en),
    .es_dvalid (es_dvalid),
    .clr_stat  (clr_stat),
    .mask_a    (mask_a),
    .mask_b    (mask_b),
    .stat      (stat),
    .irq_a     (irq_a),
    .irq_b     (irq_b)
);

// File: tb/test_sync_activity_monitor.sv
// Scoreboard bench. The driver task runs one window of stimulus and pushes
// the expected flags, status and interrupts. The monitor pops each item at
// the window boundary and compares it with the outputs.
module test_sync_activity_monitor;
    localparam int WIN_LOG2 = 6;
    localparam int WIN      = 1 << WIN_LOG2;
    localparam int NCH      = 2;

    typedef struct packed {
        logic [1:0] vs;
        logic [1:0] hs;
        logic [1:0] es;
        logic [1:0] st;
        logic       ia;
        logic       ib;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] vs_in = '0, hs_in = '0, es_in = '0;
    logic [NCH-1:0] es_det_en = '0, es_dvalid = '0, clr_stat = '0;
    logic [NCH-1:0] mask_a = '0, mask_b = '0;
    logic [NCH-1:0] vs_act, hs_act, es_act, stat;
    logic irq_a, irq_b;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    exp_t sb_q[$];
    exp_t cur;
    logic have_cur = 1'b0;
    logic [1:0] m_vs = '0, m_hs = '0, m_es = '0, m_st = '0;
    logic done = 1'b0;

    sync_activity_monitor #(.WIN_LOG2(WIN_LOG2), .MIN_EDGES(4), .NCH(NCH)) i_sync_activity_monitor (
        .clk(clk), .rst_n(rst_n), .vs_in(vs_in), .hs_in(hs_in), .es_in(es_in),
        .es_det_en(es_det_en), .es_dvalid(es_dvalid), .clr_stat(clr_stat),
        .mask_a(mask_a), .mask_b(mask_b), .vs_act(vs_act), .hs_act(hs_act),
        .es_act(es_act), .stat(stat), .irq_a(irq_a), .irq_b(irq_b)
    );

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: flags at the boundary edge, status and interrupts one cycle later.
    always @(negedge clk) begin
        if (cyc > 0 && cyc % WIN == 0 && sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            have_cur = 1'b1;
            chk("R1/R3/R4/R5/R9 vs flags", {6'd0, vs_act}, {6'd0, cur.vs});
            chk("R1/R3/R4/R5/R11 hs flags", {6'd0, hs_act}, {6'd0, cur.hs});
            chk("R1/R3/R4/R9 es flags", {6'd0, es_act}, {6'd0, cur.es});
        end else if (cyc % WIN == 1 && have_cur) begin
            have_cur = 1'b0;
            chk("R6/R7/R11 status", {6'd0, stat}, {6'd0, cur.st});
            chk("R8 irq_a", {7'd0, irq_a}, {7'd0, cur.ia});
            chk("R8 irq_b", {7'd0, irq_b}, {7'd0, cur.ib});
        end else if (cyc % WIN == 16 && cyc > 0) begin
            chk("R2 flags hold mid-window", {2'd0, vs_act, hs_act, es_act}, {2'd0, m_vs, m_hs, m_es});
        end
    end

    task automatic wait_pos(input int off);
        @(negedge clk);
        while (cyc % WIN != off) @(negedge clk);
    endtask

    // Driver: one window. Toggle counts per line are 0..8.
    task automatic run_window(input int nv0, nv1, nh0, nh1, ne0, ne1,
                              input logic [1:0] en, dv, ma, mb, clr_mid, clr_edge);
        exp_t e;
        logic [1:0] nvs, nhs, nes, chg;
        wait_pos(4);
        es_det_en = en; es_dvalid = dv; mask_a = ma; mask_b = mb;
        nvs = {nv1 >= 4, nv0 >= 4};
        nhs = {nh1 >= 4, nh0 >= 4};
        nes = {ne1 >= 4, ne0 >= 4} & en & dv;
        chg = (nvs ^ m_vs) | (nhs ^ m_hs) | (nes ^ m_es);
        m_st = chg | (m_st & ~(clr_mid | clr_edge));
        e.vs = nvs; e.hs = nhs; e.es = nes; e.st = m_st;
        e.ia = |(m_st & ma); e.ib = |(m_st & mb);
        sb_q.push_back(e);
        wait_pos(8);
        for (int s = 0; s < 8; s++) begin
            if (nv0 > s) vs_in[0] = ~vs_in[0];
            if (nv1 > s) vs_in[1] = ~vs_in[1];
            if (nh0 > s) hs_in[0] = ~hs_in[0];
            if (nh1 > s) hs_in[1] = ~hs_in[1];
            if (ne0 > s) es_in[0] = ~es_in[0];
            if (ne1 > s) es_in[1] = ~es_in[1];
            @(negedge clk);
            @(negedge clk);
        end
        wait_pos(40);
        clr_stat = clr_mid;
        @(negedge clk);
        clr_stat = '0;
        wait_pos(0);
        m_vs = nvs; m_hs = nhs; m_es = nes;
        clr_stat = clr_edge;
        @(negedge clk);
        clr_stat = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset flags", {2'd0, vs_act, hs_act, es_act}, 8'd0);
        chk("R10 reset status", {6'd0, stat}, 8'd0);
        chk("R10 reset irqs", {6'd0, irq_a, irq_b}, 8'd0);
        rst_n = 1'b1;
        // W0: all lines busy -> all flags 1, both status bits set
        run_window(8,8,8,8,8,8, 2'b11,2'b11, 2'b01,2'b10, 2'b00,2'b00);
        // W1: unchanged -> status stays sticky (R6)
        run_window(8,8,8,8,8,8, 2'b11,2'b11, 2'b01,2'b10, 2'b00,2'b00);
        // W2: ch0 vs gets 3 edges (R4), ch1 cleared mid-window (R11)
        run_window(3,8,8,8,8,8, 2'b11,2'b11, 2'b10,2'b01, 2'b11,2'b00);
        // W3: ch0 vs gets exactly 4 (R3), ch1 hs silent, set beats clear (R7)
        run_window(4,8,8,0,8,8, 2'b11,2'b11, 2'b11,2'b00, 2'b00,2'b01);
        // W4: ch0 enable low, ch1 data-valid low, embedded toggling (R9)
        run_window(4,8,8,0,8,8, 2'b10,2'b01, 2'b01,2'b11, 2'b00,2'b11);
        // W5: no change, both cleared mid-window
        run_window(4,8,8,0,8,8, 2'b10,2'b01, 2'b11,2'b11, 2'b11,2'b00);
        // W6: quiet after busy -> counts restart (R5)
        run_window(0,8,0,0,0,0, 2'b11,2'b11, 2'b11,2'b10, 2'b00,2'b00);
        // W7: no change, clear at boundary on ch1 only
        run_window(0,8,0,0,0,0, 2'b11,2'b11, 2'b11,2'b01, 2'b00,2'b10);
        wait_pos(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule